// File: doc/BRIEF.md
# Programmable Digital Input Glitch Filter

This block conditions a bank of asynchronous digital inputs before a host reads them. Each input first passes through a two-stage synchronizer. Each channel can then pass its level straight to the output, or it can go through a stability filter. The filter accepts a new level only after the input has held that level for a programmable number of 200 ns time-base ticks. All channels share one interval. A per-channel enable mask decides which channels use it.

The host uses a byte-wide register port. It writes the interval as three shadow bytes, and the interval takes effect only when the host writes a strobe. The enable mask is three more bytes. A second strobe bit restarts every channel's stability count. The filtered levels of all channels are read back as three bytes. A prescaler divides the system clock down to the tick, and its divider is a parameter.

Top module: `din_glitch_filter`

## Requirements
- R1: After reset the filtered outputs are 0, every enable bit is 0 and the active interval is 0, so every channel runs unfiltered.
- R2: A read at byte address 0x00, 0x01 or 0x02 returns the filtered levels of channels 0-7, 8-15 and 16-23 respectively, with bit k holding channel 8*byte+k. A read at any other address returns 0.
- R3: On an unfiltered channel, a level change on `din` is visible on `rd_data` after the third rising clock edge that follows it, and not after the second.
- R4: Enable bytes at 0x0C, 0x0D and 0x0E hold the mask for channels 0-7, 8-15 and 16-23, with bit k of byte b enabling channel 8*b+k. A channel whose bit is clear stays unfiltered while other channels filter.
- R5: Interval bytes at 0x08 (bits 7:0), 0x09 (bits 15:8) and 0x0A (bits 3:0 give bits 19:16, bits 7:4 are ignored) only load a shadow copy. The active interval changes only on a write to 0x07 with bit 0 set.
- R6: With its filter enabled and an active interval N > 0, a channel takes a new level only after the synchronized input has differed from the output for N ticks. With a divider of D cycles per tick, the change is not visible within 2+(N-1)*D cycles of the input change, and it is visible within 3+N*D cycles.
- R7: On a filtered channel, a pulse shorter than (N-1)*D cycles never reaches the output. Its stability count restarts whenever the input returns to the output level.
- R8: An active interval of 0 makes enabled channels behave exactly as unfiltered channels (R3 latency).
- R9: A write to 0x07 with bit 1 set clears every channel's stability count. A pending change then needs a full N further ticks after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (D cycles make one 200 ns tick) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| din | input | 24 | Raw asynchronous channel inputs |
| wr_en | input | 1 | Register write strobe, one byte per cycle |
| addr | input | 5 | Byte address for both writes and reads |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |

## Verification
An unfiltered result is due on the third rising edge after an input change, because two synchronizer flops and the output register sit in the path. The bench changes inputs at a falling edge and samples at falling edges exactly two and three edges later. A filtered result depends on the tick phase, so the bench checks a window: the old level somewhat before 2+(N-1)*D cycles, and the new level after 3+N*D cycles. The glitch and clear cases are watched every cycle or checked against the same bounds, counted from the edge on which the clear write lands.

// File: rtl/dgf_pkg.sv
package dgf_pkg;
  localparam int ADDR_W    = 5;
  localparam int FILT_BASE = 'h00;  // filtered level bytes
  localparam int CLR_ADDR  = 'h07;  // strobe register
  localparam int IV_BASE   = 'h08;  // interval shadow bytes
  localparam int EN_BASE   = 'h0C;  // enable mask bytes
  localparam int APPLY_BIT = 0;     // load shadow interval
  localparam int RESTART_BIT = 1;   // clear stability counts
endpackage

// File: rtl/dgf_tick.sv
module dgf_tick #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    if (DIV > 1) begin : g_gap
      AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick) else $error("tick twice in a row"); // R6
    end
  endgenerate
endmodule

// File: rtl/dgf_chan.sv
module dgf_chan #(
  parameter int IV_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            restart,
  input  logic            en,
  input  logic [IV_W-1:0] iv,
  input  logic            raw,
  output logic            level
);
  logic            s1_q, s2_q;
  logic            out_q, out_d;
  logic [IV_W-1:0] cnt_q, cnt_d;
  logic            filt_on;
  logic [IV_W:0]   cnt_nx;

  always_comb begin
    filt_on = en && (iv != '0);
    cnt_nx  = {1'b0, cnt_q} + 1'b1;
    cnt_d   = cnt_q;
    out_d   = out_q;
    if (!filt_on) begin
      out_d = s2_q;
      cnt_d = '0;
    end else if (s2_q == out_q) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_nx >= {1'b0, iv}) begin
        out_d = s2_q;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_nx[IV_W-1:0];
      end
    end
    if (restart) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      out_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      s1_q  <= raw;
      s2_q  <= s1_q;
      out_q <= out_d;
      cnt_q <= cnt_d;
    end
  end

  assign level = out_q;

  AST_NEW_LEVEL_FROM_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> (out_q == $past(s2_q))) else $error("output took a level not seen"); // R3
  AST_FILT_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_on && !tick) |=> $stable(out_q)) else $error("filtered output moved off tick"); // R6
endmodule

// File: rtl/dgf_regs.sv
module dgf_regs
  import dgf_pkg::*;
#(
  parameter int N_CH = 24,
  parameter int IV_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  input  logic [N_CH-1:0]   filt,
  output logic [7:0]        rd_data,
  output logic [N_CH-1:0]   en_mask,
  output logic [IV_W-1:0]   iv_act,
  output logic              restart
);
  localparam int N_BYTES  = N_CH / 8;
  localparam int IV_BYTES = (IV_W + 7) / 8;

  logic [N_CH-1:0] en_q, en_d;
  logic [IV_W-1:0] sh_q, sh_d;
  logic [IV_W-1:0] act_q, act_d;
  logic            clr_hit, apply;

  always_comb begin
    clr_hit = wr_en && (addr == ADDR_W'(CLR_ADDR));
    apply   = clr_hit && wr_data[APPLY_BIT];
    restart = clr_hit && wr_data[RESTART_BIT];

    en_d = en_q;
    for (int b = 0; b < N_BYTES; b++)
      if (wr_en && addr == ADDR_W'(EN_BASE + b)) en_d[b*8 +: 8] = wr_data;

    sh_d = sh_q;
    for (int b = 0; b < IV_BYTES; b++)
      if (wr_en && addr == ADDR_W'(IV_BASE + b))
        for (int k = 0; k < 8; k++)
          if (b*8 + k < IV_W) sh_d[b*8 + k] = wr_data[k];

    act_d = apply ? sh_q : act_q;

    rd_data = '0;
    for (int b = 0; b < N_BYTES; b++)
      if (addr == ADDR_W'(FILT_BASE + b)) rd_data = filt[b*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      sh_q  <= '0;
      act_q <= '0;
    end else begin
      en_q  <= en_d;
      sh_q  <= sh_d;
      act_q <= act_d;
    end
  end

  assign en_mask = en_q;
  assign iv_act  = act_q;

  AST_IV_ONLY_ON_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == ADDR_W'(CLR_ADDR) && wr_data[APPLY_BIT]) |=> $stable(iv_act))
    else $error("interval changed without strobe"); // R5
  AST_MASK_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_mask)) else $error("enable mask changed without write"); // R4
endmodule

// File: rtl/din_glitch_filter.sv
module din_glitch_filter
  import dgf_pkg::*;
#(
  parameter int N_CH     = 24,
  parameter int IV_W     = 20,
  parameter int TICK_DIV = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   din,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data
);
  logic            tick;
  logic            restart;
  logic [N_CH-1:0] en_mask;
  logic [N_CH-1:0] filt;
  logic [IV_W-1:0] iv_act;

  dgf_tick #(.DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  dgf_regs #(.N_CH(N_CH), .IV_W(IV_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wr_data(wr_data),
    .filt   (filt),
    .rd_data(rd_data),
    .en_mask(en_mask),
    .iv_act (iv_act),
    .restart(restart)
  );

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      dgf_chan #(.IV_W(IV_W)) u_ch (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .restart(restart),
        .en     (en_mask[c]),
        .iv     (iv_act),
        .raw    (din[c]),
        .level  (filt[c])
      );
    end
  endgenerate
endmodule

// File: tb/din_glitch_filter_tb.sv
module din_glitch_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] din;
  logic        wr_en;
  logic [4:0]  addr;
  logic [7:0]  wr_data;
  logic [7:0]  rd_data;

  int errs = 0;
  int checks = 0;

  always #10 clk = ~clk;  // 50 MHz

  din_glitch_filter u_dut (
    .clk(clk), .rst_n(rst_n), .din(din), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
  );

  // {input pattern, expected three-byte readback}
  localparam logic [47:0] VEC [6] = '{
    {24'h000001, 24'h000001},
    {24'h000080, 24'h000080},
    {24'h00A500, 24'h00A500},
    {24'h5A0000, 24'h5A0000},
    {24'hFFFFFF, 24'hFFFFFF},
    {24'h800100, 24'h800100}
  };

  task automatic chk(input string req, input logic [23:0] got, input logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wr_data = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rd_data;
  endtask

  task automatic rd_all(output logic [23:0] v);
    logic [7:0] b0, b1, b2;
    rd(5'h00, b0); rd(5'h01, b1); rd(5'h02, b2);
    v = {b2, b1, b0};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [23:0] v;
    logic [7:0]  b;
    int          bad;
    rst_n = 1'b0; din = '0; wr_en = 1'b0; addr = '0; wr_data = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1 reset state
    rd_all(v); chk("R1 reset levels", v, 24'h0);
    rd(5'h05, b); chk("R2 unmapped read", {16'h0, b}, 24'h0);
    rd(5'h0C, b); chk("R2 enable not readable", {16'h0, b}, 24'h0);

    // R2 vector table, all channels unfiltered after reset (R1)
    foreach (VEC[i]) begin
      din = VEC[i][47:24];
      cyc(4);
      rd_all(v);
      chk("R2 byte map", v, VEC[i][23:0]);
    end

    // R3 unfiltered latency
    din = '0; cyc(4);
    din = 24'h000001;
    cyc(2); rd_all(v); chk("R3 before third edge", v, 24'h0);
    cyc(1); rd_all(v); chk("R3 at third edge", v, 24'h1);

    // R5 shadow interval without strobe: still unfiltered
    wr(5'h08, 8'h05); wr(5'h09, 8'h00); wr(5'h0A, 8'hF0);
    wr(5'h0C, 8'h01);
    din = 24'h0;
    cyc(3); rd_all(v); chk("R5 no strobe no filter", v, 24'h0);
    wr(5'h07, 8'h01);  // apply N=5, upper nibble ignored

    // R6 filtered ch0 with unfiltered ch1 alongside (R4)
    din = 24'h000003;
    cyc(3);  rd_all(v); chk("R4 ch1 unfiltered ch0 held", v, 24'h000002);
    cyc(37); rd_all(v); chk("R6 early old level", v, 24'h000002);
    cyc(15); rd_all(v); chk("R6 late new level", v, 24'h000003);

    // R7 glitch of 30 cycles must not pass
    bad = 0;
    din[0] = 1'b0;
    for (int i = 0; i < 100; i++) begin
      if (i == 30) din[0] = 1'b1;
      cyc(1);
      rd(5'h00, b);
      if (b[0] !== 1'b1) bad++;
    end
    chk("R7 glitch suppressed", 24'(bad), 24'h0);

    // R9 restart clears stability count
    din[0] = 1'b0;
    cyc(35);
    wr(5'h07, 8'h02);
    cyc(38); rd(5'h00, b); chk("R9 count restarted", {23'h0, b[0]}, 24'h1);
    cyc(20); rd(5'h00, b); chk("R9 passes after full interval", {23'h0, b[0]}, 24'h0);

    // R4 byte 0x0E controls channel 16 only
    wr(5'h0C, 8'h00); wr(5'h0E, 8'h01);
    din = 24'h030000;
    cyc(4);  rd(5'h02, b); chk("R4 ch17 free ch16 filtered", {16'h0, b}, 24'h000002);
    cyc(60); rd(5'h02, b); chk("R4 ch16 after interval", {16'h0, b}, 24'h000003);

    // R8 interval zero behaves unfiltered
    wr(5'h08, 8'h00); wr(5'h0A, 8'h00); wr(5'h07, 8'h01);
    din = 24'h020000;
    cyc(3); rd(5'h02, b); chk("R8 zero interval latency", {16'h0, b}, 24'h000002);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule